// File: doc/BRIEF.md
# Split Isochronous Descriptor Stepper

This block holds the live transfer state of one split-transaction isochronous descriptor for a high-speed host. Each time the schedule walker visits the descriptor in a micro-frame, the block takes a one-hot micro-frame index. It decides from the descriptor's scheduling masks whether a start-split or a complete-split is due. When one is due, it raises a request that carries the payload length and the payload position code. It then waits for the bus side to report that the transaction has finished.

Start-splits get no handshake, so the block advances the descriptor after every one of them. For OUT transfers it lowers the remaining byte count and raises the buffer offset. It also flips the page select when the offset wraps, moves the position code along, lowers the split count and records progress in a mask. An OUT start-split that finds an earlier scheduled micro-frame missing from the progress mask retires the descriptor instead of sending data. For IN transfers, the start-split moves the descriptor into the complete phase. Complete-splits then run in the micro-frames named by the complete mask.

A descriptor image is loaded through a single-cycle load strobe. The updated fields stay visible on the state outputs, and a one-cycle write-back pulse marks each change for the memory side.

Top module: `split_iso_stepper`

## Requirements
- R1: After reset the descriptor is inactive, no request is pending and the write-back pulse is low.
- R2: A start-split request is raised only when a visit arrives while the descriptor is active, in the start phase, with no request pending, and the micro-frame bit is also set in the start mask. The request and its length are held until the done strobe, and visits that arrive while it is pending change nothing.
- R3: An OUT start-split carries min(remaining bytes, 188). An IN start-split carries length 0. A complete-split request names min(remaining bytes, 188) as its ceiling.
- R4: When an OUT start-split finishes, the remaining bytes drop by the sent length and the offset rises by it. The current micro-frame bit is ORed into the progress mask, and the split count drops by one.
- R5: The position code is 2'b00 all, 2'b01 begin, 2'b10 mid, 2'b11 end. After an OUT start-split it becomes end when the new split count is 1. Otherwise it moves from begin to mid, and any other value is kept.
- R6: By default the descriptor retires when an OUT start-split brings the split count to zero. The number of start-splits follows the split count, not the number of start-mask bits. An inactive descriptor never has a request pending.
- R7: A descriptor loaded with 0 bytes and a split count of 1 issues exactly one start-split of length 0 and then retires.
- R8: When the offset sum carries out of the 12-bit offset, the page select toggles and the offset keeps the low 12 bits.
- R9: Before an OUT start-split, the block checks the highest start-mask bit below the current micro-frame. If that bit is missing from the progress mask, the descriptor retires, no request is raised and write-back pulses.
- R10: When an IN start-split finishes, the block enters the complete phase, reported as 1. In that phase a complete-split request is raised only in micro-frames whose bit is set in the complete mask.
- R11: When a complete-split finishes, the received length is clipped to the remaining bytes. The remaining bytes drop by that length and the offset rises by it. The descriptor retires if no higher complete-mask bit remains.
- R12: The split count never goes below zero. A finished OUT start-split with a count of 0 leaves it at 0 and retires the descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load the descriptor image below |
| ld_active | input | 1 | Image: active flag |
| ld_dir_in | input | 1 | Image: 1 = IN endpoint, 0 = OUT |
| ld_smask | input | UF | Image: start-split micro-frame mask |
| ld_cmask | input | UF | Image: complete-split micro-frame mask |
| ld_prog | input | UF | Image: progress mask |
| ld_tp | input | 2 | Image: payload position code |
| ld_tcount | input | TC_W | Image: start-split count |
| ld_bytes | input | BYTES_W | Image: bytes left to move |
| ld_offset | input | OFF_W | Image: buffer offset |
| ld_page | input | 1 | Image: page select |
| uf_visit | input | 1 | Descriptor visited this micro-frame |
| uf_onehot | input | UF | One-hot current micro-frame |
| xact_done | input | 1 | Requested bus transaction has finished |
| xact_rx_len | input | BYTES_W | Bytes received by a complete-split |
| req_valid | output | 1 | A split transaction is requested |
| req_is_complete | output | 1 | 1 = complete-split, 0 = start-split |
| req_len | output | BYTES_W | Payload length (or ceiling for complete) |
| req_tp | output | 2 | Position code sent with the split |
| wb_valid | output | 1 | Fields updated; write back this cycle |
| st_active | output | 1 | Active flag |
| st_phase_cs | output | 1 | 1 = complete phase |
| st_tp | output | 2 | Position code |
| st_tcount | output | TC_W | Split count |
| st_bytes | output | BYTES_W | Bytes left |
| st_offset | output | OFF_W | Buffer offset |
| st_page | output | 1 | Page select |
| st_prog | output | UF | Progress mask |

## Verification
The hardest state to reach from the ports is a skipped OUT micro-frame. In normal running the progress mask is always complete, because every scheduled start-split executes in order. The bench gets there by loading a descriptor image whose progress mask lacks an earlier start-mask bit and then visiting a later scheduled micro-frame. It then loads the same image with the bit present to show that the split goes ahead. The page wrap and the underflow guard are reached the same way, through loaded offsets near the 4 KB edge and a zero split count.

// File: rtl/split_iso_pkg.sv
package split_iso_pkg;
   typedef enum logic [1:0] {
      TP_ALL   = 2'b00,
      TP_BEGIN = 2'b01,
      TP_MID   = 2'b10,
      TP_END   = 2'b11
   } tp_e;

   typedef enum logic {
      PH_START    = 1'b0,
      PH_COMPLETE = 1'b1
   } phase_e;
endpackage

// File: rtl/split_iso_sched.sv
// Micro-frame schedule tests: mask hits, previous-start check, last-complete check.
module split_iso_sched #(
   parameter int UF = 8
) (
   input  logic [UF-1:0] uframe,
   input  logic [UF-1:0] smask,
   input  logic [UF-1:0] cmask,
   input  logic [UF-1:0] prog,
   output logic          s_hit,
   output logic          c_hit,
   output logic          prev_ok,
   output logic          c_last
);
   logic [UF-1:0] below, above, cand, top;

   always_comb begin
      below = uframe - UF'(1);
      above = ~(below | uframe);
      cand  = smask & below;
      top   = '0;
      for (int i = 0; i < UF; i++) begin
         if (cand[i]) top = UF'(1) << i;
      end
   end

   assign s_hit   = |(uframe & smask);
   assign c_hit   = |(uframe & cmask);
   assign prev_ok = ~|(top & ~prog);
   assign c_last  = ~|(cmask & above);
endmodule

// File: rtl/split_iso_advance.sv
// Arithmetic for one step of the descriptor: length, bytes, offset, page, count, position.
module split_iso_advance
   import split_iso_pkg::*;
#(
   parameter int BYTES_W         = 10,
   parameter int OFF_W           = 12,
   parameter int TC_W            = 6,
   parameter int MAX_PAY         = 188,
   parameter bit RETIRE_BY_BYTES = 1'b0
) (
   input  logic [BYTES_W-1:0] bytes,
   input  logic [OFF_W-1:0]   offset,
   input  logic               page,
   input  logic [TC_W-1:0]    tcount,
   input  logic [1:0]         tp,
   input  logic [BYTES_W-1:0] len_in,
   output logic [BYTES_W-1:0] pay_len,
   output logic [BYTES_W-1:0] nbytes,
   output logic [OFF_W-1:0]   noffset,
   output logic               npage,
   output logic [TC_W-1:0]    ntcount,
   output logic [1:0]         ntp,
   output logic               retire
);
   localparam logic [BYTES_W-1:0] PAY_CAP = BYTES_W'(MAX_PAY);
   logic [OFF_W:0] sum;

   always_comb begin
      pay_len = (bytes > PAY_CAP) ? PAY_CAP : bytes;
      nbytes  = bytes - len_in;
      sum     = {1'b0, offset} + (OFF_W+1)'(len_in);
      noffset = sum[OFF_W-1:0];
      npage   = page ^ sum[OFF_W];
      ntcount = (tcount == '0) ? '0 : tcount - TC_W'(1);
      if (ntcount == TC_W'(1))  ntp = TP_END;
      else if (tp == TP_BEGIN)  ntp = TP_MID;
      else                      ntp = tp;
   end

   if (RETIRE_BY_BYTES) begin : g_retire_bytes
      assign retire = (nbytes == '0);
   end else begin : g_retire_count
      assign retire = (ntcount == '0);
   end
endmodule

// File: rtl/split_iso_stepper.sv
module split_iso_stepper
   import split_iso_pkg::*;
#(
   parameter int UF              = 8,
   parameter int BYTES_W         = 10,
   parameter int OFF_W           = 12,
   parameter int TC_W            = 6,
   parameter int MAX_PAY         = 188,
   parameter bit RETIRE_BY_BYTES = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_valid,
   input  logic               ld_active,
   input  logic               ld_dir_in,
   input  logic [UF-1:0]      ld_smask,
   input  logic [UF-1:0]      ld_cmask,
   input  logic [UF-1:0]      ld_prog,
   input  logic [1:0]         ld_tp,
   input  logic [TC_W-1:0]    ld_tcount,
   input  logic [BYTES_W-1:0] ld_bytes,
   input  logic [OFF_W-1:0]   ld_offset,
   input  logic               ld_page,
   input  logic               uf_visit,
   input  logic [UF-1:0]      uf_onehot,
   input  logic               xact_done,
   input  logic [BYTES_W-1:0] xact_rx_len,
   output logic               req_valid,
   output logic               req_is_complete,
   output logic [BYTES_W-1:0] req_len,
   output logic [1:0]         req_tp,
   output logic               wb_valid,
   output logic               st_active,
   output logic               st_phase_cs,
   output logic [1:0]         st_tp,
   output logic [TC_W-1:0]    st_tcount,
   output logic [BYTES_W-1:0] st_bytes,
   output logic [OFF_W-1:0]   st_offset,
   output logic               st_page,
   output logic [UF-1:0]      st_prog
);
   if (UF < 2) begin : g_bad_uf
      $error("split_iso_stepper: UF must be at least 2");
   end
   if (BYTES_W > OFF_W) begin : g_bad_bw
      $error("split_iso_stepper: BYTES_W must not exceed OFF_W");
   end
   if (MAX_PAY >= (1 << BYTES_W) || MAX_PAY < 1) begin : g_bad_pay
      $error("split_iso_stepper: MAX_PAY must fit in BYTES_W");
   end

   // descriptor registers
   logic               active_q, dir_in_q, cs_last_q;
   phase_e             phase_q;
   logic [UF-1:0]      smask_q, cmask_q, prog_q, cur_uf_q;
   logic [1:0]         tp_q;
   logic [TC_W-1:0]    tcount_q;
   logic [BYTES_W-1:0] bytes_q;
   logic [OFF_W-1:0]   offset_q;
   logic               page_q;
   logic               busy_q, kind_cs_q, wb_q;
   logic [BYTES_W-1:0] len_q;
   logic [1:0]         rtp_q;

   // schedule tests
   logic s_hit, c_hit, prev_ok, c_last;

   split_iso_sched #(.UF(UF)) u_sched (
      .uframe (uf_onehot),
      .smask  (smask_q),
      .cmask  (cmask_q),
      .prog   (prog_q),
      .s_hit  (s_hit),
      .c_hit  (c_hit),
      .prev_ok(prev_ok),
      .c_last (c_last)
   );

   // step arithmetic
   logic [BYTES_W-1:0] rx_eff, step_len, pay_len, nbytes;
   logic [OFF_W-1:0]   noffset;
   logic               npage, retire;
   logic [TC_W-1:0]    ntcount;
   logic [1:0]         ntp;

   always_comb begin
      rx_eff   = (xact_rx_len > bytes_q) ? bytes_q : xact_rx_len;
      step_len = kind_cs_q ? rx_eff : len_q;
   end

   split_iso_advance #(
      .BYTES_W        (BYTES_W),
      .OFF_W          (OFF_W),
      .TC_W           (TC_W),
      .MAX_PAY        (MAX_PAY),
      .RETIRE_BY_BYTES(RETIRE_BY_BYTES)
   ) u_adv (
      .bytes  (bytes_q),
      .offset (offset_q),
      .page   (page_q),
      .tcount (tcount_q),
      .tp     (tp_q),
      .len_in (step_len),
      .pay_len(pay_len),
      .nbytes (nbytes),
      .noffset(noffset),
      .npage  (npage),
      .ntcount(ntcount),
      .ntp    (ntp),
      .retire (retire)
   );

   logic finish_now, visit_ok;
   assign finish_now = busy_q && xact_done;
   assign visit_ok   = uf_visit && active_q && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         dir_in_q  <= 1'b0;
         cs_last_q <= 1'b0;
         phase_q   <= PH_START;
         smask_q   <= '0;
         cmask_q   <= '0;
         prog_q    <= '0;
         cur_uf_q  <= '0;
         tp_q      <= TP_ALL;
         tcount_q  <= '0;
         bytes_q   <= '0;
         offset_q  <= '0;
         page_q    <= 1'b0;
         busy_q    <= 1'b0;
         kind_cs_q <= 1'b0;
         wb_q      <= 1'b0;
         len_q     <= '0;
         rtp_q     <= TP_ALL;
      end else begin
         wb_q <= 1'b0;
         if (ld_valid) begin
            active_q  <= ld_active;
            dir_in_q  <= ld_dir_in;
            smask_q   <= ld_smask;
            cmask_q   <= ld_cmask;
            prog_q    <= ld_prog;
            tp_q      <= ld_tp;
            tcount_q  <= ld_tcount;
            bytes_q   <= ld_bytes;
            offset_q  <= ld_offset;
            page_q    <= ld_page;
            phase_q   <= PH_START;
            busy_q    <= 1'b0;
            cs_last_q <= 1'b0;
         end else if (finish_now) begin
            busy_q <= 1'b0;
            wb_q   <= 1'b1;
            if (kind_cs_q) begin
               bytes_q  <= nbytes;
               offset_q <= noffset;
               page_q   <= npage;
               if (cs_last_q) active_q <= 1'b0;
            end else if (dir_in_q) begin
               phase_q <= PH_COMPLETE;
            end else begin
               bytes_q  <= nbytes;
               offset_q <= noffset;
               page_q   <= npage;
               tcount_q <= ntcount;
               tp_q     <= ntp;
               prog_q   <= prog_q | cur_uf_q;
               if (retire) active_q <= 1'b0;
            end
         end else if (visit_ok) begin
            if (phase_q == PH_START && s_hit) begin
               if (!dir_in_q && !prev_ok) begin
                  active_q <= 1'b0;
                  wb_q     <= 1'b1;
               end else begin
                  busy_q    <= 1'b1;
                  kind_cs_q <= 1'b0;
                  len_q     <= dir_in_q ? '0 : pay_len;
                  rtp_q     <= tp_q;
                  cur_uf_q  <= uf_onehot;
               end
            end else if (phase_q == PH_COMPLETE && c_hit) begin
               busy_q    <= 1'b1;
               kind_cs_q <= 1'b1;
               len_q     <= pay_len;
               rtp_q     <= tp_q;
               cur_uf_q  <= uf_onehot;
               cs_last_q <= c_last;
            end
         end
      end
   end

   assign req_valid       = busy_q;
   assign req_is_complete = kind_cs_q;
   assign req_len         = len_q;
   assign req_tp          = rtp_q;
   assign wb_valid        = wb_q;
   assign st_active       = active_q;
   assign st_phase_cs     = (phase_q == PH_COMPLETE);
   assign st_tp           = tp_q;
   assign st_tcount       = tcount_q;
   assign st_bytes        = bytes_q;
   assign st_offset       = offset_q;
   assign st_page         = page_q;
   assign st_prog         = prog_q;
endmodule

// File: rtl/split_iso_stepper_chk.sv
module split_iso_stepper_chk #(
   parameter int UF      = 8,
   parameter int BYTES_W = 10,
   parameter int OFF_W   = 12,
   parameter int TC_W    = 6,
   parameter int MAX_PAY = 188
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_valid,
   input logic               xact_done,
   input logic               req_valid,
   input logic               req_is_complete,
   input logic [BYTES_W-1:0] req_len,
   input logic               wb_valid,
   input logic               st_active,
   input logic [TC_W-1:0]    st_tcount,
   input logic [BYTES_W-1:0] st_bytes
);
   assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_complete) |-> (req_len <= BYTES_W'(MAX_PAY)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xact_done && !ld_valid) |=> (req_valid && $stable(req_len)));

   assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> (st_tcount <= $past(st_tcount)));

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && xact_done && !ld_valid) |=>
         (st_tcount == $past(st_tcount) || st_tcount == $past(st_tcount) - TC_W'(1)));

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !st_active |-> !req_valid);

   assert_bytes_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> (st_bytes <= $past(st_bytes)));

   assert_wb_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && xact_done && !ld_valid) |=> wb_valid);
endmodule

bind split_iso_stepper split_iso_stepper_chk #(
   .UF(UF), .BYTES_W(BYTES_W), .OFF_W(OFF_W), .TC_W(TC_W), .MAX_PAY(MAX_PAY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .xact_done(xact_done),
   .req_valid(req_valid), .req_is_complete(req_is_complete), .req_len(req_len),
   .wb_valid(wb_valid), .st_active(st_active), .st_tcount(st_tcount),
   .st_bytes(st_bytes)
);

// File: tb/tb_split_iso_stepper.sv
`timescale 1ns/1ps
module tb_split_iso_stepper;
   localparam int UF = 8, BW = 10, OW = 12, TW = 6;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          ld_valid = 0, ld_active = 0, ld_dir_in = 0, ld_page = 0;
   logic [UF-1:0] ld_smask = 0, ld_cmask = 0, ld_prog = 0, uf_onehot = 0;
   logic [1:0]    ld_tp = 0;
   logic [TW-1:0] ld_tcount = 0;
   logic [BW-1:0] ld_bytes = 0, xact_rx_len = 0;
   logic [OW-1:0] ld_offset = 0;
   logic          uf_visit = 0, xact_done = 0;
   logic          req_valid, req_is_complete, wb_valid, st_active, st_phase_cs, st_page;
   logic [BW-1:0] req_len, st_bytes;
   logic [1:0]    req_tp, st_tp;
   logic [TW-1:0] st_tcount;
   logic [OW-1:0] st_offset;
   logic [UF-1:0] st_prog;

   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   split_iso_stepper dut (.*);

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(bit dir_in, logic [7:0] sm, logic [7:0] cm, logic [7:0] pg,
                       logic [1:0] tp, int tc, int by, int off, bit page);
      ld_valid = 1; ld_active = 1; ld_dir_in = dir_in; ld_smask = sm; ld_cmask = cm;
      ld_prog = pg; ld_tp = tp; ld_tcount = TW'(tc); ld_bytes = BW'(by);
      ld_offset = OW'(off); ld_page = page;
      @(negedge clk); ld_valid = 0;
   endtask

   task automatic visit(int uf);
      uf_visit = 1; uf_onehot = UF'(1) << uf;
      @(negedge clk); uf_visit = 0;
   endtask

   task automatic done(int rx);
      xact_done = 1; xact_rx_len = BW'(rx);
      @(negedge clk); xact_done = 0;
   endtask

   task automatic t_reset;
      check("R1 active", st_active, 0);
      check("R1 req", req_valid, 0);
      check("R1 wb", wb_valid, 0);
   endtask

   task automatic t_out_three;
      load(0, 8'h07, 8'h00, 8'h00, 2'b01, 3, 400, 0, 0);
      visit(3);
      check("R2 no hit off smask", req_valid, 0);
      visit(0);
      check("R2 req", req_valid, 1);
      check("R3 len cap", req_len, 188);
      check("R5 tp begin sent", req_tp, 1);
      visit(1);
      check("R2 held len", req_len, 188);
      check("R2 busy visit ignored", st_tcount, 3);
      done(0);
      check("R4 wb pulse", wb_valid, 1);
      check("R4 bytes", st_bytes, 212);
      check("R4 offset", st_offset, 188);
      check("R4 tcount", st_tcount, 2);
      check("R4 prog", st_prog, 1);
      check("R5 mid", st_tp, 2);
      visit(1); done(0);
      check("R5 end", st_tp, 3);
      check("R4 bytes2", st_bytes, 24);
      visit(2);
      check("R3 tail len", req_len, 24);
      done(0);
      check("R6 retire", st_active, 0);
      check("R4 bytes zero", st_bytes, 0);
      check("R6 prog full", st_prog, 7);
   endtask

   task automatic t_zero_len;
      load(0, 8'h01, 8'h00, 8'h00, 2'b00, 1, 0, 0, 0);
      visit(0);
      check("R7 one req", req_valid, 1);
      check("R7 zero len", req_len, 0);
      done(0);
      check("R7 retire", st_active, 0);
      visit(0);
      check("R7 no second", req_valid, 0);
   endtask

   task automatic t_count_rules;
      load(0, 8'hFF, 8'h00, 8'h00, 2'b00, 1, 10, 0, 0);
      visit(0); done(0);
      check("R6 count governs", st_active, 0);
      visit(1);
      check("R6 no extra split", req_valid, 0);
      load(0, 8'h01, 8'h00, 8'h00, 2'b00, 0, 5, 0, 0);
      visit(0);
      check("R12 len", req_len, 5);
      done(0);
      check("R12 no underflow", st_tcount, 0);
      check("R12 retire", st_active, 0);
   endtask

   task automatic t_page;
      load(0, 8'h01, 8'h00, 8'h00, 2'b00, 1, 188, 'hF80, 0);
      visit(0); done(0);
      check("R8 offset wrap", st_offset, 'h03C);
      check("R8 page toggled", st_page, 1);
   endtask

   task automatic t_skip;
      load(0, 8'h06, 8'h00, 8'h00, 2'b01, 2, 100, 0, 0);
      visit(2);
      check("R9 no req on skip", req_valid, 0);
      check("R9 wb on abort", wb_valid, 1);
      check("R9 retired", st_active, 0);
      load(0, 8'h06, 8'h00, 8'h02, 2'b01, 2, 100, 0, 0);
      visit(2);
      check("R9 prev present issues", req_valid, 1);
      done(0);
      check("R9 active kept", st_active, 1);
   endtask

   task automatic t_in;
      load(1, 8'h01, 8'h0C, 8'h00, 2'b00, 1, 300, 0, 0);
      visit(0);
      check("R3 in start len", req_len, 0);
      check("R3 in start kind", req_is_complete, 0);
      done(0);
      check("R10 complete phase", st_phase_cs, 1);
      check("R10 bytes unchanged", st_bytes, 300);
      visit(1);
      check("R10 no cmask hit", req_valid, 0);
      visit(2);
      check("R10 complete req", req_is_complete, 1);
      check("R3 complete ceiling", req_len, 188);
      done(100);
      check("R11 bytes", st_bytes, 200);
      check("R11 offset", st_offset, 100);
      check("R11 still active", st_active, 1);
      visit(3); done(250);
      check("R11 clipped bytes", st_bytes, 0);
      check("R11 last retire", st_active, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_out_three();
      t_zero_len();
      t_count_rules();
      t_page();
      t_skip();
      t_in();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule